// File: doc/BRIEF.md
# Modulo 2^n+1 Prefix Adder

This block adds two residues modulo 2^n+1 in a single combinational pass. Each operand is n+1 bits wide and holds a value from 0 to 2^n. The result always comes out fully reduced into that same range. A modular arithmetic unit uses it as a building block, for example inside residue-number pipelines or transform butterflies, where the value 2^n is a legal residue.

The operands first pass through a carry-free row of dual half-adder cells. This row turns them into two n-bit words whose sum is offset by 2^n - 1. The carry that would leave the top of that row is folded back into the free least-significant slot, since 2^n is congruent to -1.

A Sklansky parallel-prefix adder then sums the two words. Its carry-in enters late, after the prefix tree, and it is driven by a single gate. That gate watches the full-width group status, which is kill, propagate or generate. The same status also supplies the top result bit.

When either operand equals 2^n, operand multiplexers in the pre-stage substitute values that steer the same datapath to the correct residue. No separate output path is needed for that case.

Top module: `modp1_prefix_adder`

## Requirements
- R1: For operands A and B in 0..2^n, sum_o equals (A + B) mod (2^n + 1).
- R2: sum_o never exceeds 2^n, and whenever sum_o bit n is 1, bits n-1..0 are all 0.
- R3: An operand whose bit n is 1 is taken as the value 2^n, and its bits n-1..0 have no effect on sum_o.
- R4: When both operands equal 2^n, sum_o equals 2^n - 1.
- R5: When exactly one operand equals 2^n and the other has value V, sum_o equals V - 1 for V > 0, and 2^n for V = 0.
- R6: An operand of value 0 leaves the other operand unchanged at sum_o.
- R7: Exchanging a_i and b_i does not change sum_o.
- R8: The block is purely combinational: sum_o settles to the result of the present operands without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N+1 | First residue, 0..2^N; bit N set means 2^N |
| b_i | input | N+1 | Second residue, 0..2^N; bit N set means 2^N |
| sum_o | output | N+1 | Fully reduced residue (a_i + b_i) mod (2^N + 1) |

## Verification
Two mechanisms can fire in the same evaluation. One is the late +1 correction, applied when the prefix tree does not report generate. The other is the top-bit output, which is set when the tree reports propagate across the full width. Both are provoked by operand pairs that sum to exactly 2^n, such as 31 + 1 and 16 + 16 for n = 5, where the correction must ripple all the way into bit n and clear the low bits.

Operand-substitution cases, where one or both operands equal 2^n, also push the adder through its generate and propagate boundaries. They are judged both by table entries with hand-computed residues and by an exhaustive sweep of every operand pair against an arithmetic model in the bench.

// File: rtl/modp1_pkg.sv
package modp1_pkg;

   // Carry status of a bit group as seen by a late carry-in.
   typedef enum logic [1:0] {
      GRP_KILL = 2'b00,
      GRP_PROP = 2'b01,
      GRP_GEN  = 2'b10
   } grp_status_e;

   function automatic grp_status_e grp_encode(input logic g, input logic p);
      if (g)      return GRP_GEN;
      else if (p) return GRP_PROP;
      else        return GRP_KILL;
   endfunction

endpackage

// File: rtl/modp1_prestage.sv
// Carry-free operand reshaping with the 2^n operand substitution.
module modp1_prestage #(
   parameter int N = 8
) (
   input  logic [N:0]   a_i,
   input  logic [N:0]   b_i,
   output logic [N-1:0] x_o,
   output logic [N-1:0] y_o
);
   logic         a_top, b_top;
   logic [N-1:0] a_sel, b_sel;
   logic [N:1]   xs;

   assign a_top = a_i[N];
   assign b_top = b_i[N];

   // Operand equal to 2^n behaves as -1; rewrite the pair so the shared
   // datapath lands on the right residue.
   always_comb begin
      unique case ({a_top, b_top})
         2'b00: begin a_sel = a_i[N-1:0]; b_sel = b_i[N-1:0]; end
         2'b01: begin a_sel = '1;         b_sel = a_i[N-1:0]; end
         2'b10: begin a_sel = '1;         b_sel = b_i[N-1:0]; end
         default: begin a_sel = '1;       b_sel = '0;         end
      endcase
   end

   // Dual half-adder row: a_k + b_k = 2*(a_k|b_k) + xnor(a_k,b_k) - 1.
   for (genvar k = 0; k < N; k++) begin : g_dha
      assign y_o[k]  = ~(a_sel[k] ^ b_sel[k]);
      assign xs[k+1] = a_sel[k] | b_sel[k];
   end

   // Weight 2^n folds to -1; its slot becomes the complement in bit 0.
   assign x_o[0] = ~xs[N] | (a_top ^ b_top);
   for (genvar k = 1; k < N; k++) begin : g_xmv
      assign x_o[k] = xs[k];
   end

endmodule

// File: rtl/modp1_sklansky_late.sv
// Sklansky prefix tree; the carry-in is applied after the tree.
module modp1_sklansky_late
   import modp1_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0] x_i,
   input  logic [N-1:0] y_i,
   input  logic         cin_i,
   output grp_status_e  grp_o,
   output logic [N-1:0] sum_o
);
   localparam int LVL = (N > 1) ? $clog2(N) : 1;

   logic [LVL:0][N-1:0] gv, pv;
   logic [N-1:0]        carry;

   assign gv[0] = x_i & y_i;
   assign pv[0] = x_i ^ y_i;

   for (genvar l = 0; l < LVL; l++) begin : g_lvl
      for (genvar i = 0; i < N; i++) begin : g_bit
         if (((i >> l) & 1) == 1) begin : g_node
            localparam int J = ((i >> l) << l) - 1;
            assign gv[l+1][i] = gv[l][i] | (pv[l][i] & gv[l][J]);
            assign pv[l+1][i] = pv[l][i] & pv[l][J];
         end else begin : g_pass
            assign gv[l+1][i] = gv[l][i];
            assign pv[l+1][i] = pv[l][i];
         end
      end
   end

   assign carry[0] = cin_i;
   for (genvar i = 1; i < N; i++) begin : g_late
      assign carry[i] = gv[LVL][i-1] | (pv[LVL][i-1] & cin_i);
   end

   assign sum_o = pv[0] ^ carry;
   assign grp_o = grp_encode(gv[LVL][N-1], pv[LVL][N-1]);

endmodule

// File: rtl/modp1_prefix_adder.sv
module modp1_prefix_adder
   import modp1_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N:0] a_i,
   input  logic [N:0] b_i,
   output logic [N:0] sum_o
);
   if (N < 2 || N > 30) begin : g_bad_width
      $error("modp1_prefix_adder: N must lie in 2..30");
   end

   logic [N-1:0] x_w, y_w, low_w;
   grp_status_e  top_grp;
   logic         plus_one;

   modp1_prestage #(.N(N)) u_pre (
      .a_i (a_i),
      .b_i (b_i),
      .x_o (x_w),
      .y_o (y_w)
   );

   modp1_sklansky_late #(.N(N)) u_tree (
      .x_i   (x_w),
      .y_i   (y_w),
      .cin_i (plus_one),
      .grp_o (top_grp),
      .sum_o (low_w)
   );

   // Wrap-around of the n-bit sum already subtracts one; otherwise add it back.
   assign plus_one = ~(top_grp == GRP_GEN);
   assign sum_o    = {(top_grp == GRP_PROP) & plus_one, low_w};

endmodule

// File: rtl/modp1_checker.sv
module modp1_checker
   import modp1_pkg::*;
#(
   parameter int N = 8
) (
   input logic [N:0]  a_i,
   input logic [N:0]  b_i,
   input logic [N:0]  sum_o,
   input grp_status_e grp_i
);
   localparam longint MODV = (64'd1 << N) + 64'd1;
   localparam longint TOPV = 64'd1 << N;

   longint va, vb, vs;

   always_comb begin
      va = a_i[N] ? TOPV : longint'(a_i[N-1:0]);
      vb = b_i[N] ? TOPV : longint'(b_i[N-1:0]);
      vs = longint'(sum_o);
      AST_MOD_SUM: assert (vs == (va + vb) % MODV) else $error("mod sum"); // R1
      AST_IN_RANGE: assert (vs <= TOPV) else $error("range"); // R2
      AST_TOP_CLEAN: assert (!sum_o[N] || sum_o[N-1:0] == '0) else $error("top"); // R2
      AST_BOTH_TOP: assert (!(a_i[N] && b_i[N]) || vs == TOPV - 1) else $error("both"); // R4
      AST_ONE_TOP: assert (!(a_i[N] ^ b_i[N]) ||
         vs == ((a_i[N] ? vb : va) == 0 ? TOPV : (a_i[N] ? vb : va) - 1)) else $error("one"); // R5
      AST_ZERO_ID: assert (vb != 0 || vs == va) else $error("zero"); // R6
      AST_GEN_NO_TOP: assert (grp_i != GRP_GEN || !sum_o[N]) else $error("gen"); // R2
   end
endmodule

bind modp1_prefix_adder modp1_checker #(.N(N)) u_chk (
   .a_i   (a_i),
   .b_i   (b_i),
   .sum_o (sum_o),
   .grp_i (top_grp)
);

// File: tb/tb_modp1_prefix_adder.sv
`timescale 1ns/1ps
module tb_modp1_prefix_adder;
   localparam int N = 5;
   localparam int M = (1 << N) + 1;

   logic       clk = 1'b0;
   logic [N:0] a, b;
   logic [N:0] s;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done  = 1'b0;

   always #10 clk = ~clk;

   modp1_prefix_adder #(.N(N)) dut (.a_i(a), .b_i(b), .sum_o(s));

   // {a, b, expected}, 6 bits each, residues mod 33.
   localparam logic [17:0] VEC [0:14] = '{
      {6'd0,  6'd0,  6'd0},   // R6
      {6'd1,  6'd1,  6'd2},   // R1
      {6'd31, 6'd1,  6'd32},  // R2 carry into top bit
      {6'd16, 6'd16, 6'd32},  // R2
      {6'd31, 6'd2,  6'd0},   // R1 wrap
      {6'd31, 6'd31, 6'd29},  // R1
      {6'd20, 6'd13, 6'd0},   // R1
      {6'd32, 6'd0,  6'd32},  // R5
      {6'd32, 6'd1,  6'd0},   // R5
      {6'd32, 6'd5,  6'd4},   // R5
      {6'd5,  6'd32, 6'd4},   // R5
      {6'd0,  6'd32, 6'd32},  // R5
      {6'd32, 6'd32, 6'd31},  // R4
      {6'd39, 6'd3,  6'd2},   // R3 low bits of 2^n ignored
      {6'd63, 6'd63, 6'd31}   // R3
   };

   task automatic check(input string req, input logic [N:0] got, input logic [N:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: a=%0d b=%0d got %0d expected %0d", req, a, b, got, exp);
      end
   endtask

   function automatic int model(input int x, input int y);
      return (x + y) % M;
   endfunction

   initial begin
      logic [N:0] first;
      a = '0; b = '0;
      #3;
      check("R8 settle", s, '0);

      foreach (VEC[k]) begin
         @(negedge clk);
         a = VEC[k][17:12];
         b = VEC[k][11:6];
         #2;
         check("R1-table", s, VEC[k][5:0]);
      end

      // R7 and R8: swap operands without any clock edge in between
      a = 6'd17; b = 6'd25; #1;
      first = s;
      check("R1 R8", s, 6'(model(17, 25)));
      a = 6'd25; b = 6'd17; #1;
      check("R7 swap", s, first);

      // R3: low bits of a 2^n operand must not matter
      for (int lo = 0; lo < 32; lo++) begin
         a = 6'(32 + lo); b = 6'd9; #1;
         check("R3 ignore", s, 6'd8);
      end

      // R1 exhaustive sweep, R7 on every pair, R2 range
      for (int x = 0; x <= 32; x++) begin
         for (int y = 0; y <= 32; y++) begin
            a = 6'(x); b = 6'(y); #1;
            check("R1 sweep", s, 6'(model(x, y)));
            if (s > 6'd32 || (s[N] && s[N-1:0] != '0)) check("R2 range", s, 6'(model(x, y)));
            first = s;
            a = 6'(y); b = 6'(x); #1;
            check("R7 sweep", s, first);
         end
      end

      // R6 identity over every value
      for (int x = 0; x <= 32; x++) begin
         a = 6'(x); b = 6'd0; #1;
         check("R6 zero", s, 6'(x));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule